// File: doc/BRIEF.md
# CAN Fault Confinement Unit

This block keeps the error bookkeeping of a CAN node. A protocol engine, outside this block, detects bus-level errors and reports each outcome as a one-cycle pulse: a receive error (light or heavy), a good reception, a transmit error, a good transmission, and the type of the error it saw. From these pulses the unit keeps a receive counter and a transmit counter, each 8 bits wide. It derives three node states from them: warning, error-passive and bus-off. It also holds the most recent error type as a 3-bit code that software may overwrite.

Once the transmit counter would pass its maximum, the node goes bus-off and every counting event is frozen. Recovery starts once it is armed, either by a software request or, with the automatic recovery option on, without any software action. The engine then reports each run of eleven recessive bits, and the 128th such report ends bus-off and zeroes both counters. One interrupt flag is shared by the warning, passive, bus-off and error-code sources, each behind its own enable, and writing 1 clears it. A packed status word presents the counters in the upper bytes, where software expects them.

Top module: `fault_confine`

## Requirements
- R1: A synchronous active-high reset clears both counters, the warning, passive, bus-off and interrupt flags, and the error code to 0.
- R2: A receive error adds 1 to the receive counter, or 8 when the heavy input is high, saturating at 255.
- R3: A good reception sets the receive counter to 120 when it is above 128, otherwise decrements it and holds it at 0. A receive error in the same cycle wins and the success is ignored.
- R4: A transmit error adds 8 to the transmit counter and a good transmission subtracts 1, holding at 0. The error wins when both arrive together.
- R5: The warning flag is high exactly when either counter is 96 or more.
- R6: The passive flag is high exactly when either counter is 128 or more and the node is not bus-off.
- R7: A transmit error that would take the transmit counter above 255 sets bus-off and leaves that counter at 255. While bus-off, all four counting events leave both counters unchanged.
- R8: Recovery is armed by auto_recover_en being high, or by a sw_recover_req pulse while bus-off, which takes effect from the next cycle. Only while armed, each recess_seq_evt pulse is counted. The 128th counted pulse clears bus-off and sets both counters to 0. Unarmed pulses have no effect.
- R9: The error code takes err_code_in on err_code_evt, or sw_lec_val on sw_lec_wr, and the engine wins when both occur. The codes are 0 none, 1 stuff, 2 form, 3 acknowledge, 4 bit-recessive, 5 bit-dominant, 6 CRC and 7 software-set.
- R10: The interrupt flag is set when any of these happens with its enable high: a rise of warning, a rise of passive, a rise of bus-off, or an engine error event with a nonzero code. It is cleared by an irq_clr pulse, and a set in the same cycle wins.
- R11: err_view holds the receive counter in bits 31:24, the transmit counter in 23:16, the error code in 6:4, bus-off in bit 2, passive in bit 1 and warning in bit 0. All other bits are 0.
- R12: Every output reflects an input pulse from the first clock edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_err_evt | input | 1 | Receive error pulse |
| rx_err_heavy | input | 1 | With rx_err_evt: the error weighs 8 |
| rx_ok_evt | input | 1 | Good reception pulse |
| tx_err_evt | input | 1 | Transmit error pulse |
| tx_ok_evt | input | 1 | Good transmission pulse |
| err_code_evt | input | 1 | Engine reports an error type |
| err_code_in | input | 3 | Error type from the engine |
| sw_lec_wr | input | 1 | Software write of the error code |
| sw_lec_val | input | 3 | Error code written by software |
| recess_seq_evt | input | 1 | Eleven consecutive recessive bits seen |
| auto_recover_en | input | 1 | Automatic bus-off recovery enable |
| sw_recover_req | input | 1 | Software request to start recovery |
| warn_ie | input | 1 | Interrupt enable for warning |
| passive_ie | input | 1 | Interrupt enable for passive |
| busoff_ie | input | 1 | Interrupt enable for bus-off |
| lec_ie | input | 1 | Interrupt enable for error-code events |
| irq_clr | input | 1 | Write-1 clear of the interrupt flag |
| rx_cnt | output | 8 | Receive error counter |
| tx_cnt | output | 8 | Transmit error counter |
| warn_flag | output | 1 | Warning state |
| passive_flag | output | 1 | Error-passive state |
| busoff_flag | output | 1 | Bus-off state |
| lec_code | output | 3 | Last error code |
| err_irq_flag | output | 1 | Shared error interrupt flag |
| err_view | output | 32 | Packed status word |

## Verification
The hardest state to reach from the ports is the recovery edge. The node has to be driven into bus-off by 32 transmit errors, which passes through warning and passive on the way. Then exactly 127 armed recessive-sequence pulses must arrive with the flag still set, and the 128th must clear both counters in one edge. The stimulus does this twice. In the first run, a long stretch of unarmed pulses comes before the software request. In the second, the automatic option is on and idle cycles are mixed in between the pulses. A long pseudo-random stream weighted toward transmit errors then keeps cycling the node through bus-off and recovery. During that stream the enables and modes are toggled, and every cycle is compared against an arithmetic model.

// File: rtl/fc_pkg.sv
package fc_pkg;
  // Last-error codes; values are fixed because software decodes them.
  typedef enum logic [2:0] {
    LEC_NONE  = 3'd0,
    LEC_STUFF = 3'd1,
    LEC_FORM  = 3'd2,
    LEC_ACK   = 3'd3,
    LEC_BIT1  = 3'd4,
    LEC_BIT0  = 3'd5,
    LEC_CRC   = 3'd6,
    LEC_SOFT  = 3'd7
  } lec_e;

  localparam int unsigned LEC_W  = 3;
  localparam int unsigned VIEW_W = 32;
endpackage

// File: rtl/fc_rx_counter.sv
module fc_rx_counter #(
  parameter int unsigned CNT_W        = 8,
  parameter int unsigned HEAVY_STEP   = 8,
  parameter int unsigned RELOAD_ABOVE = 128,
  parameter int unsigned RELOAD_VAL   = 120
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             freeze,
  input  logic             clear,
  input  logic             err_evt,
  input  logic             err_heavy,
  input  logic             ok_evt,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_d
);
  localparam logic [CNT_W-1:0] MAX_C    = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] HEAVY_C  = CNT_W'(HEAVY_STEP);
  localparam logic [CNT_W-1:0] ONE_C    = CNT_W'(1);
  localparam logic [CNT_W-1:0] ABOVE_C  = CNT_W'(RELOAD_ABOVE);
  localparam logic [CNT_W-1:0] RELOAD_C = CNT_W'(RELOAD_VAL);

  logic [CNT_W:0] sum;

  always_comb begin
    sum   = {1'b0, cnt_q} + {1'b0, (err_heavy ? HEAVY_C : ONE_C)};
    cnt_d = cnt_q;
    if (clear) begin
      cnt_d = '0;
    end else if (!freeze) begin
      if (err_evt) begin
        cnt_d = sum[CNT_W] ? MAX_C : sum[CNT_W-1:0];
      end else if (ok_evt) begin
        if (cnt_q > ABOVE_C)    cnt_d = RELOAD_C;
        else if (cnt_q != '0)   cnt_d = cnt_q - ONE_C;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end
endmodule

// File: rtl/fc_tx_busoff.sv
module fc_tx_busoff #(
  parameter int unsigned CNT_W        = 8,
  parameter int unsigned TX_STEP      = 8,
  parameter int unsigned RECOVER_SEQS = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             err_evt,
  input  logic             ok_evt,
  input  logic             recess_evt,
  input  logic             auto_en,
  input  logic             sw_req,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_d,
  output logic             busoff_q,
  output logic             busoff_d,
  output logic             recover_now
);
  localparam int unsigned      SEQ_W  = $clog2(RECOVER_SEQS + 1);
  localparam logic [SEQ_W-1:0] LAST_C = SEQ_W'(RECOVER_SEQS - 1);
  localparam logic [CNT_W-1:0] STEP_C = CNT_W'(TX_STEP);
  localparam logic [CNT_W-1:0] MAX_C  = {CNT_W{1'b1}};

  logic [CNT_W:0]   sum;
  logic [SEQ_W-1:0] seq_q;
  logic             armed_q;
  logic             armed_eff;
  logic             enter;
  logic             count_seq;

  always_comb begin
    sum         = {1'b0, cnt_q} + {1'b0, STEP_C};
    enter       = !busoff_q && err_evt && sum[CNT_W];
    armed_eff   = armed_q || auto_en;
    count_seq   = busoff_q && armed_eff && recess_evt;
    recover_now = count_seq && (seq_q == LAST_C);
    busoff_d    = enter ? 1'b1 : (recover_now ? 1'b0 : busoff_q);
    cnt_d       = cnt_q;
    if (recover_now) begin
      cnt_d = '0;
    end else if (!busoff_q) begin
      if (err_evt)                    cnt_d = enter ? MAX_C : sum[CNT_W-1:0];
      else if (ok_evt && cnt_q != '0) cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      busoff_q <= 1'b0;
      seq_q    <= '0;
      armed_q  <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      busoff_q <= busoff_d;
      if (enter || recover_now)  seq_q <= '0;
      else if (count_seq)        seq_q <= seq_q + SEQ_W'(1);
      if (enter || recover_now)  armed_q <= 1'b0;
      else if (busoff_q && sw_req) armed_q <= 1'b1;
    end
  end
endmodule

// File: rtl/fc_status.sv
module fc_status
  import fc_pkg::*;
#(
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned WARN_LVL    = 96,
  parameter int unsigned PASSIVE_LVL = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] rx_d,
  input  logic [CNT_W-1:0] tx_d,
  input  logic             busoff_q,
  input  logic             busoff_d,
  input  logic             code_evt,
  input  logic [LEC_W-1:0] code_in,
  input  logic             sw_wr,
  input  logic [LEC_W-1:0] sw_val,
  input  logic             warn_ie,
  input  logic             passive_ie,
  input  logic             busoff_ie,
  input  logic             lec_ie,
  input  logic             irq_clr,
  output logic             warn_q,
  output logic             passive_q,
  output logic [LEC_W-1:0] lec_q,
  output logic             irq_q
);
  localparam logic [CNT_W-1:0] WARN_C = CNT_W'(WARN_LVL);
  localparam logic [CNT_W-1:0] PASS_C = CNT_W'(PASSIVE_LVL);

  logic warn_d;
  logic passive_d;
  logic irq_set;

  always_comb begin
    warn_d    = (rx_d >= WARN_C) || (tx_d >= WARN_C);
    passive_d = ((rx_d >= PASS_C) || (tx_d >= PASS_C)) && !busoff_d;
    irq_set   = (warn_ie    && warn_d    && !warn_q)    ||
                (passive_ie && passive_d && !passive_q) ||
                (busoff_ie  && busoff_d  && !busoff_q)  ||
                (lec_ie     && code_evt  && (code_in != LEC_NONE));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      warn_q    <= 1'b0;
      passive_q <= 1'b0;
      lec_q     <= LEC_NONE;
      irq_q     <= 1'b0;
    end else begin
      warn_q    <= warn_d;
      passive_q <= passive_d;
      if (code_evt)   lec_q <= code_in;
      else if (sw_wr) lec_q <= sw_val;
      if (irq_set)      irq_q <= 1'b1;
      else if (irq_clr) irq_q <= 1'b0;
    end
  end
endmodule

// File: rtl/fault_confine.sv
module fault_confine
  import fc_pkg::*;
#(
  parameter int unsigned CNT_W        = 8,
  parameter int unsigned RX_HEAVY     = 8,
  parameter int unsigned TX_STEP      = 8,
  parameter int unsigned RELOAD_ABOVE = 128,
  parameter int unsigned RELOAD_VAL   = 120,
  parameter int unsigned WARN_LVL     = 96,
  parameter int unsigned PASSIVE_LVL  = 128,
  parameter int unsigned RECOVER_SEQS = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_err_evt,
  input  logic             rx_err_heavy,
  input  logic             rx_ok_evt,
  input  logic             tx_err_evt,
  input  logic             tx_ok_evt,
  input  logic             err_code_evt,
  input  logic [2:0]       err_code_in,
  input  logic             sw_lec_wr,
  input  logic [2:0]       sw_lec_val,
  input  logic             recess_seq_evt,
  input  logic             auto_recover_en,
  input  logic             sw_recover_req,
  input  logic             warn_ie,
  input  logic             passive_ie,
  input  logic             busoff_ie,
  input  logic             lec_ie,
  input  logic             irq_clr,
  output logic [CNT_W-1:0] rx_cnt,
  output logic [CNT_W-1:0] tx_cnt,
  output logic             warn_flag,
  output logic             passive_flag,
  output logic             busoff_flag,
  output logic [2:0]       lec_code,
  output logic             err_irq_flag,
  output logic [31:0]      err_view
);
  localparam int unsigned PAD_W = VIEW_W - 2 * CNT_W - LEC_W - 4;

  logic [CNT_W-1:0] rx_d;
  logic [CNT_W-1:0] tx_d;
  logic             boff_d;
  logic             recover_now;

  fc_rx_counter #(
    .CNT_W(CNT_W), .HEAVY_STEP(RX_HEAVY),
    .RELOAD_ABOVE(RELOAD_ABOVE), .RELOAD_VAL(RELOAD_VAL)
  ) rx_u (
    .clk(clk), .rst(rst), .freeze(busoff_flag), .clear(recover_now),
    .err_evt(rx_err_evt), .err_heavy(rx_err_heavy), .ok_evt(rx_ok_evt),
    .cnt_q(rx_cnt), .cnt_d(rx_d)
  );

  fc_tx_busoff #(
    .CNT_W(CNT_W), .TX_STEP(TX_STEP), .RECOVER_SEQS(RECOVER_SEQS)
  ) tx_u (
    .clk(clk), .rst(rst), .err_evt(tx_err_evt), .ok_evt(tx_ok_evt),
    .recess_evt(recess_seq_evt), .auto_en(auto_recover_en),
    .sw_req(sw_recover_req), .cnt_q(tx_cnt), .cnt_d(tx_d),
    .busoff_q(busoff_flag), .busoff_d(boff_d), .recover_now(recover_now)
  );

  fc_status #(
    .CNT_W(CNT_W), .WARN_LVL(WARN_LVL), .PASSIVE_LVL(PASSIVE_LVL)
  ) st_u (
    .clk(clk), .rst(rst), .rx_d(rx_d), .tx_d(tx_d),
    .busoff_q(busoff_flag), .busoff_d(boff_d),
    .code_evt(err_code_evt), .code_in(err_code_in),
    .sw_wr(sw_lec_wr), .sw_val(sw_lec_val),
    .warn_ie(warn_ie), .passive_ie(passive_ie), .busoff_ie(busoff_ie),
    .lec_ie(lec_ie), .irq_clr(irq_clr),
    .warn_q(warn_flag), .passive_q(passive_flag), .lec_q(lec_code),
    .irq_q(err_irq_flag)
  );

  // Counter fields sit at the top of the word; R11 layout.
  assign err_view = {rx_cnt, tx_cnt, {PAD_W{1'b0}}, lec_code, 1'b0,
                     busoff_flag, passive_flag, warn_flag};
endmodule

// File: rtl/fc_checker.sv
module fc_checker #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             rx_err_evt,
  input logic             rx_ok_evt,
  input logic             tx_err_evt,
  input logic             tx_ok_evt,
  input logic             err_code_evt,
  input logic [2:0]       err_code_in,
  input logic             irq_clr,
  input logic [CNT_W-1:0] rx_cnt,
  input logic [CNT_W-1:0] tx_cnt,
  input logic             warn_flag,
  input logic             passive_flag,
  input logic             busoff_flag,
  input logic [2:0]       lec_code,
  input logic             err_irq_flag
);
  localparam logic [CNT_W-1:0] MAX_C = {CNT_W{1'b1}};

  a_r2_rx_saturate: assert property (@(posedge clk) disable iff (rst)
    (rx_cnt == MAX_C && rx_err_evt && !busoff_flag) |=> rx_cnt == MAX_C);

  a_r3_rx_reload: assert property (@(posedge clk) disable iff (rst)
    (!busoff_flag && !rx_err_evt && rx_ok_evt && rx_cnt > CNT_W'(128))
      |=> rx_cnt == CNT_W'(120));

  a_r4_tx_step: assert property (@(posedge clk) disable iff (rst)
    (!busoff_flag && tx_err_evt && tx_cnt < CNT_W'(248))
      |=> tx_cnt == CNT_W'($past(tx_cnt) + CNT_W'(8)));

  a_r5_warn_level: assert property (@(posedge clk) disable iff (rst)
    warn_flag == ((rx_cnt >= CNT_W'(96)) || (tx_cnt >= CNT_W'(96))));

  a_r6_passive_not_busoff: assert property (@(posedge clk) disable iff (rst)
    !(passive_flag && busoff_flag));

  a_r7_frozen: assert property (@(posedge clk) disable iff (rst)
    busoff_flag |=> (!busoff_flag || ($stable(rx_cnt) && $stable(tx_cnt))));

  a_r8_recover_zero: assert property (@(posedge clk) disable iff (rst)
    $fell(busoff_flag) |-> (rx_cnt == '0 && tx_cnt == '0));

  a_r9_engine_code: assert property (@(posedge clk) disable iff (rst)
    err_code_evt |=> lec_code == $past(err_code_in));

  a_r10_irq_hold: assert property (@(posedge clk) disable iff (rst)
    (err_irq_flag && !irq_clr) |=> err_irq_flag);
endmodule

bind fault_confine fc_checker #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst(rst), .rx_err_evt(rx_err_evt), .rx_ok_evt(rx_ok_evt),
  .tx_err_evt(tx_err_evt), .tx_ok_evt(tx_ok_evt),
  .err_code_evt(err_code_evt), .err_code_in(err_code_in), .irq_clr(irq_clr),
  .rx_cnt(rx_cnt), .tx_cnt(tx_cnt), .warn_flag(warn_flag),
  .passive_flag(passive_flag), .busoff_flag(busoff_flag),
  .lec_code(lec_code), .err_irq_flag(err_irq_flag)
);

// File: tb/fault_confine_tb_top.sv
`timescale 1ns/1ps
module fault_confine_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst = 1'b1;
  logic rx_err_evt = 0, rx_err_heavy = 0, rx_ok_evt = 0, tx_err_evt = 0, tx_ok_evt = 0;
  logic err_code_evt = 0, sw_lec_wr = 0, recess_seq_evt = 0;
  logic [2:0] err_code_in = 0, sw_lec_val = 0;
  logic auto_recover_en = 0, sw_recover_req = 0;
  logic warn_ie = 0, passive_ie = 0, busoff_ie = 0, lec_ie = 0, irq_clr = 0;
  logic [7:0] rx_cnt, tx_cnt;
  logic warn_flag, passive_flag, busoff_flag, err_irq_flag;
  logic [2:0] lec_code;
  logic [31:0] err_view;

  fault_confine dut_i (
    .clk(clk), .rst(rst), .rx_err_evt(rx_err_evt), .rx_err_heavy(rx_err_heavy),
    .rx_ok_evt(rx_ok_evt), .tx_err_evt(tx_err_evt), .tx_ok_evt(tx_ok_evt),
    .err_code_evt(err_code_evt), .err_code_in(err_code_in),
    .sw_lec_wr(sw_lec_wr), .sw_lec_val(sw_lec_val),
    .recess_seq_evt(recess_seq_evt), .auto_recover_en(auto_recover_en),
    .sw_recover_req(sw_recover_req), .warn_ie(warn_ie), .passive_ie(passive_ie),
    .busoff_ie(busoff_ie), .lec_ie(lec_ie), .irq_clr(irq_clr),
    .rx_cnt(rx_cnt), .tx_cnt(tx_cnt), .warn_flag(warn_flag),
    .passive_flag(passive_flag), .busoff_flag(busoff_flag),
    .lec_code(lec_code), .err_irq_flag(err_irq_flag), .err_view(err_view)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // Arithmetic model of the requirements.
  int m_rx, m_tx, m_seq, m_lec;
  bit m_boff, m_armed, m_warn, m_pass, m_irq;

  task automatic chk_eq(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    longint v;
    v = (longint'(m_rx) << 24) | (longint'(m_tx) << 16) | (longint'(m_lec) << 4) |
        (longint'(m_boff) << 2) | (longint'(m_pass) << 1) | longint'(m_warn);
    chk_eq("R2 R3 R12", "rx_cnt", rx_cnt, m_rx);
    chk_eq("R4 R12", "tx_cnt", tx_cnt, m_tx);
    chk_eq("R7 R8", "busoff_flag", busoff_flag, m_boff);
    chk_eq("R5", "warn_flag", warn_flag, m_warn);
    chk_eq("R6", "passive_flag", passive_flag, m_pass);
    chk_eq("R9", "lec_code", lec_code, m_lec);
    chk_eq("R10", "err_irq_flag", err_irq_flag, m_irq);
    chk_eq("R11", "err_view", err_view, v);
  endtask

  task automatic idle();
    rx_err_evt = 0; rx_err_heavy = 0; rx_ok_evt = 0; tx_err_evt = 0; tx_ok_evt = 0;
    err_code_evt = 0; sw_lec_wr = 0; recess_seq_evt = 0; sw_recover_req = 0; irq_clr = 0;
  endtask

  task automatic tick();
    int nrx, ntx, nseq, nlec;
    bit enter, rec, armed_eff, nboff, narmed, nwarn, npass, set;
    enter     = !m_boff && tx_err_evt && (m_tx + 8 > 255);
    armed_eff = m_armed || auto_recover_en;
    rec       = m_boff && armed_eff && recess_seq_evt && (m_seq == 127);
    if (rec) ntx = 0;
    else if (m_boff) ntx = m_tx;
    else if (tx_err_evt) ntx = enter ? 255 : m_tx + 8;
    else if (tx_ok_evt && m_tx > 0) ntx = m_tx - 1;
    else ntx = m_tx;
    if (rec) nrx = 0;
    else if (m_boff) nrx = m_rx;
    else if (rx_err_evt) nrx = (m_rx + (rx_err_heavy ? 8 : 1) > 255) ? 255 : m_rx + (rx_err_heavy ? 8 : 1);
    else if (rx_ok_evt) nrx = (m_rx > 128) ? 120 : ((m_rx > 0) ? m_rx - 1 : 0);
    else nrx = m_rx;
    nseq   = (enter || rec) ? 0 : ((m_boff && armed_eff && recess_seq_evt) ? m_seq + 1 : m_seq);
    narmed = (enter || rec) ? 0 : ((m_boff && sw_recover_req) ? 1 : m_armed);
    nboff  = enter ? 1 : (rec ? 0 : m_boff);
    nwarn  = (nrx >= 96) || (ntx >= 96);
    npass  = ((nrx >= 128) || (ntx >= 128)) && !nboff;
    set    = (warn_ie && nwarn && !m_warn) || (passive_ie && npass && !m_pass) ||
             (busoff_ie && nboff && !m_boff) || (lec_ie && err_code_evt && err_code_in != 0);
    nlec   = err_code_evt ? int'(err_code_in) : (sw_lec_wr ? int'(sw_lec_val) : m_lec);
    @(posedge clk);
    #1;
    m_rx = nrx; m_tx = ntx; m_seq = nseq; m_armed = narmed; m_boff = nboff;
    m_warn = nwarn; m_pass = npass; m_lec = nlec;
    m_irq = set ? 1'b1 : (irq_clr ? 1'b0 : m_irq);
    compare_all();
    idle();
  endtask

  task automatic do_reset();
    idle();
    rst = 1;
    repeat (3) @(posedge clk);
    #1;
    rst = 0;
    m_rx = 0; m_tx = 0; m_seq = 0; m_lec = 0;
    m_boff = 0; m_armed = 0; m_warn = 0; m_pass = 0; m_irq = 0;
    compare_all();  // R1 reset state
  endtask

  task automatic drive_busoff();
    while (!busoff_flag) begin tx_err_evt = 1; tick(); end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    chk_eq("R1", "rx after reset", rx_cnt, 0);
    chk_eq("R1", "view after reset", err_view, 0);

    // R2 / R5 / R6 receive side ramp
    repeat (95) begin rx_err_evt = 1; tick(); end
    chk_eq("R5", "warn at 95", warn_flag, 0);
    rx_err_evt = 1; tick();
    chk_eq("R5", "warn at 96", warn_flag, 1);
    repeat (3) begin rx_err_evt = 1; rx_err_heavy = 1; tick(); end
    repeat (7) begin rx_err_evt = 1; tick(); end
    chk_eq("R6", "passive at 127", passive_flag, 0);
    rx_err_evt = 1; tick();
    chk_eq("R6", "passive at 128", passive_flag, 1);
    rx_ok_evt = 1; tick();
    chk_eq("R3", "ok at 128 decrements", rx_cnt, 127);
    rx_err_evt = 1; rx_err_heavy = 1; tick();
    chk_eq("R2", "heavy adds 8", rx_cnt, 135);
    rx_ok_evt = 1; tick();
    chk_eq("R3", "ok above 128 reloads", rx_cnt, 120);
    repeat (20) begin rx_err_evt = 1; rx_err_heavy = 1; tick(); end
    chk_eq("R2", "rx saturates", rx_cnt, 255);
    rx_err_evt = 1; rx_ok_evt = 1; tick();
    chk_eq("R3", "error wins over success", rx_cnt, 255);
    rx_ok_evt = 1; tick();
    chk_eq("R3", "ok at 255 reloads", rx_cnt, 120);

    // R4 / R7 transmit side
    do_reset();
    repeat (31) begin tx_err_evt = 1; tick(); end
    chk_eq("R4", "31 tx errors", tx_cnt, 248);
    tx_ok_evt = 1; tick();
    chk_eq("R4", "tx success", tx_cnt, 247);
    tx_err_evt = 1; tx_ok_evt = 1; tick();
    chk_eq("R4", "tx error wins, reaches 255", tx_cnt, 255);
    chk_eq("R7", "no busoff at 255", busoff_flag, 0);
    tx_ok_evt = 1; tick();
    tx_err_evt = 1; tick();
    chk_eq("R7", "busoff entered", busoff_flag, 1);
    chk_eq("R7", "tx held at 255", tx_cnt, 255);
    chk_eq("R6", "passive masked in busoff", passive_flag, 0);
    rx_err_evt = 1; rx_err_heavy = 1; tick();
    tx_ok_evt = 1; rx_ok_evt = 1; tick();
    chk_eq("R7", "rx frozen", rx_cnt, 0);
    chk_eq("R7", "tx frozen", tx_cnt, 255);

    // R8 software-armed recovery
    repeat (200) begin recess_seq_evt = 1; tick(); end
    chk_eq("R8", "unarmed pulses ignored", busoff_flag, 1);
    sw_recover_req = 1; recess_seq_evt = 1; tick();
    repeat (127) begin recess_seq_evt = 1; tick(); end
    chk_eq("R8", "still busoff after 127", busoff_flag, 1);
    recess_seq_evt = 1; tick();
    chk_eq("R8", "recovered after 128", busoff_flag, 0);
    chk_eq("R8", "tx cleared", tx_cnt, 0);

    // R8 automatic recovery with gaps
    rx_err_evt = 1; rx_err_heavy = 1; tick();
    drive_busoff();
    auto_recover_en = 1;
    for (int i = 0; i < 127; i++) begin
      recess_seq_evt = 1; tick();
      if (i % 3 == 0) tick();
    end
    chk_eq("R8", "auto: busoff after 127", busoff_flag, 1);
    recess_seq_evt = 1; tick();
    chk_eq("R8", "auto: recovered", busoff_flag, 0);
    chk_eq("R8", "auto: rx cleared", rx_cnt, 0);
    auto_recover_en = 0;

    // R9 error code
    err_code_evt = 1; err_code_in = 3'd3; tick();
    chk_eq("R9", "engine code ack", lec_code, 3);
    sw_lec_wr = 1; sw_lec_val = 3'd7; tick();
    chk_eq("R9", "software code 7", lec_code, 7);
    err_code_evt = 1; err_code_in = 3'd5; sw_lec_wr = 1; sw_lec_val = 3'd7; tick();
    chk_eq("R9", "engine wins", lec_code, 5);
    sw_lec_wr = 1; sw_lec_val = 3'd0; tick();
    chk_eq("R9", "software clears", lec_code, 0);

    // R10 interrupt
    do_reset();
    repeat (96) begin rx_err_evt = 1; tick(); end
    chk_eq("R10", "disabled source no irq", err_irq_flag, 0);
    warn_ie = 1;
    repeat (20) begin rx_ok_evt = 1; tick(); end
    repeat (20) begin rx_err_evt = 1; tick(); end
    chk_eq("R10", "warn rise sets irq", err_irq_flag, 1);
    irq_clr = 1; tick();
    chk_eq("R10", "w1 clear", err_irq_flag, 0);
    lec_ie = 1;
    err_code_evt = 1; err_code_in = 3'd0; tick();
    chk_eq("R10", "code 0 no irq", err_irq_flag, 0);
    err_code_evt = 1; err_code_in = 3'd6; irq_clr = 1; tick();
    chk_eq("R10", "set beats clear", err_irq_flag, 1);
    irq_clr = 1; tick();
    warn_ie = 0; lec_ie = 0;

    // Pseudo-random stream against the model (R2..R12)
    for (int i = 0; i < 30000; i++) begin
      if (i % 1000 == 0) begin
        auto_recover_en = $urandom_range(0, 1);
        warn_ie = $urandom_range(0, 1); passive_ie = $urandom_range(0, 1);
        busoff_ie = $urandom_range(0, 1); lec_ie = $urandom_range(0, 1);
      end
      tx_err_evt     = ($urandom_range(0, 9) < 4);
      tx_ok_evt      = ($urandom_range(0, 9) < 2);
      rx_err_evt     = ($urandom_range(0, 9) < 4);
      rx_err_heavy   = $urandom_range(0, 1);
      rx_ok_evt      = ($urandom_range(0, 9) < 3);
      recess_seq_evt = ($urandom_range(0, 9) < 6);
      sw_recover_req = ($urandom_range(0, 49) == 0);
      err_code_evt   = ($urandom_range(0, 9) == 0);
      err_code_in    = 3'($urandom_range(0, 7));
      sw_lec_wr      = ($urandom_range(0, 19) == 0);
      sw_lec_val     = 3'($urandom_range(0, 7));
      irq_clr        = ($urandom_range(0, 9) == 0);
      tick();
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule